// File: doc/BRIEF.md
# MDIO Management Master with Continuous Register Scan

This block lets a MAC's host bus reach the management registers of an external PHY over the two-wire MDC/MDIO interface. Software loads a target PHY address, a target register address and a 16-bit value into small holding registers. It then writes a command word that starts a single read, a single write, or a continuous scan of one PHY register. The block builds each clause-22 frame itself, drives MDC from a divided system clock, and places the 16 bits returned by every read into a read-only result register.

A status word gives three flags: access in progress, scan enabled, and "first scan result not yet in". A host that turns the scan on can therefore wait for the pending flag to drop before it trusts the result register. After that it may poll the result register freely, because scan frames follow one another with no idle MDC period. The MDIO pad is left to the caller: the block exposes a separate data-out, output-enable and data-in signal.

Host access is word-indexed through `reg_addr`: 0 address, 1 write value, 2 read result, 3 status, 4 command. Register reads are combinational on `reg_rdata`.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: Index 0 keeps the PHY address in bits 12:8 and the PHY register address in bits 4:0. All its other bits read 0, whatever was written.
- R3: Index 1 stores the 16-bit write value in bits 15:0, with bits 31:16 reading 0. A host write to index 2 (read result) has no effect.
- R4: `mdc` has a period of `DIV` system clocks, with `DIV/2` low followed by `DIV/2` high, and starts low.
- R5: Command bit 1 starts a write frame. Its 64 bits go out MSB first with `mdio_oe` high throughout: 32 ones, 01, opcode 01, PHY address, register address, turnaround 10, then the 16-bit write value.
- R6: Command bit 0 starts a read frame with the same header and opcode 10. `mdio_oe` drops for the two turnaround bits and the 16 data bits. `mdio_i` is sampled just before each of the 16 data-bit MDC rises, and the 16 bits are placed in index 2 when the frame ends.
- R7: `mdio_o` and `mdio_oe` change only in the system clock cycle in which `mdc` falls.
- R8: Status bit 0 (busy) is 1 from the cycle after an accepted command until the last MDC period of its frame ends. It is also 1 while scan is enabled. `mdio_oe` stays 0 while busy is 0.
- R9: Command bits 0 and 1 are ignored while busy is 1, or when the same command word sets bit 2. If both are set, the write wins.
- R10: Command bit 2 enables scan, and status bit 1 mirrors it. While scan is on, the block issues read frames of the addressed register back to back, with exactly one MDC period between the last bit rise of one frame and the first bit rise of the next. Index 2 updates after every frame.
- R11: Status bit 2 becomes 1 when command bit 2 goes from 0 to 1. It becomes 0 when the first read frame issued under that scan ends.
- R12: Clearing command bit 2 lets the read frame in progress finish. After that no further frame starts and busy returns to 0.
- R13: Status bits 31:3 read 0. Index 4 reads back the scan bit in bit 2, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Host write strobe, one cycle per write |
| reg_addr | input | 3 | Host word index for read and write |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data to the pad |
| mdio_oe | output | 1 | Pad drive enable, 1 = block drives MDIO |
| mdio_i | input | 1 | Management data from the pad |

## Verification
The properties assume that the PHY drives `mdio_i` only while `mdio_oe` is low and changes it only after an MDC fall. They also assume that the host writes registers as single-cycle strobes. The bench's PHY responder keeps to this by updating `mdio_i` on MDC falls of the data phase only and holding it at 1 otherwise. The host tasks raise `reg_wr` for one cycle, away from the clock edge. The properties also take it that a new scan is not requested during the very cycle a scan frame ends. The stimulus meets this because it writes commands only at chosen points inside frames, not at their boundaries.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = 46;  // first turnaround bit index
  localparam int DATA_POS   = 48;  // first data bit index
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam logic [2:0] RA_ADDR   = 3'd0;
  localparam logic [2:0] RA_WVAL   = 3'd1;
  localparam logic [2:0] RA_RVAL   = 3'd2;
  localparam logic [2:0] RA_STATUS = 3'd3;
  localparam logic [2:0] RA_CMD    = 3'd4;

  typedef struct packed {
    logic [4:0]  phy;
    logic [4:0]  reg_ad;
    logic [15:0] data;
    logic        is_wr;
    logic        scan;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick = (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    mdc_d = tick ? ~mdc_q : mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = tick & ~mdc_q;
  assign fall_tick = tick & mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        req,
  input  mdio_req_t   req_info,
  output logic        take,
  output logic        done_rd,
  output logic        done_scan,
  output logic [15:0] rdata,
  output logic        running,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                  run_q, run_d;
  logic                  wr_q, wr_d;
  logic                  scan_q, scan_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [15:0]           cap_q, cap_d;
  logic                  last, done;
  logic [FRAME_BITS-1:0] frame;

  assign last = run_q && (idx_q == IDX_W'(FRAME_BITS - 1));
  assign take = fall_tick && req && (!run_q || last);
  assign done = fall_tick && last;

  assign frame = {{PRE_BITS{1'b1}}, 2'b01,
                  req_info.is_wr ? 2'b01 : 2'b10,
                  req_info.phy, req_info.reg_ad,
                  req_info.is_wr ? 2'b10 : 2'b00,
                  req_info.is_wr ? req_info.data : 16'h0000};

  always_comb begin
    run_d  = run_q;
    wr_d   = wr_q;
    scan_d = scan_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    cap_d  = cap_q;
    if (rise_tick && run_q && !wr_q && idx_q >= IDX_W'(DATA_POS))
      cap_d = {cap_q[14:0], mdio_i};
    if (fall_tick) begin
      if (take) begin
        run_d  = 1'b1;
        wr_d   = req_info.is_wr;
        scan_d = req_info.scan;
        idx_d  = '0;
        sh_d   = frame;
      end else if (last) begin
        run_d = 1'b0;
        idx_d = '0;
        sh_d  = '0;
      end else if (run_q) begin
        idx_d = idx_q + 1'b1;
        sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wr_q   <= 1'b0;
      scan_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else begin
      run_q  <= run_d;
      wr_q   <= wr_d;
      scan_q <= scan_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      cap_q  <= cap_d;
    end
  end

  assign done_rd   = done && !wr_q;
  assign done_scan = done && scan_q;
  assign rdata     = cap_q;
  assign running   = run_q;
  assign mdio_o    = run_q & sh_q[FRAME_BITS-1];
  assign mdio_oe   = run_q && (wr_q || idx_q < IDX_W'(TA_POS));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic rise_tick, fall_tick;
  logic take, done_rd, done_scan, running;
  logic [15:0] eng_rdata;

  logic [4:0]  phy_q, phy_d, rga_q, rga_d;
  logic [15:0] wval_q, wval_d, rval_q, rval_d;
  logic        scan_q, scan_d, nvalid_q, nvalid_d;
  logic        pend_q, pend_d, pwr_q, pwr_d;
  logic        busy, cmd_wr, go_ok, req;
  mdio_req_t   req_info;
  logic        unused_hi;

  assign unused_hi = ^reg_wdata[31:16];

  mdio_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  assign busy   = pend_q | running | scan_q;
  assign cmd_wr = reg_wr && (reg_addr == RA_CMD);
  assign go_ok  = cmd_wr && !busy && !reg_wdata[2] && (reg_wdata[0] | reg_wdata[1]);
  assign req    = pend_q | scan_q;

  always_comb begin
    req_info.phy    = phy_q;
    req_info.reg_ad = rga_q;
    req_info.data   = wval_q;
    req_info.is_wr  = !scan_q && pwr_q;
    req_info.scan   = scan_q;
  end

  mdio_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .req(req), .req_info(req_info), .take(take), .done_rd(done_rd),
    .done_scan(done_scan), .rdata(eng_rdata), .running(running),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always_comb begin
    phy_d    = phy_q;
    rga_d    = rga_q;
    wval_d   = wval_q;
    rval_d   = rval_q;
    scan_d   = scan_q;
    nvalid_d = nvalid_q;
    pend_d   = pend_q;
    pwr_d    = pwr_q;
    if (reg_wr && reg_addr == RA_ADDR) begin
      phy_d = reg_wdata[12:8];
      rga_d = reg_wdata[4:0];
    end
    if (reg_wr && reg_addr == RA_WVAL) wval_d = reg_wdata[15:0];
    if (done_rd) rval_d = eng_rdata;
    if (cmd_wr) scan_d = reg_wdata[2];
    if (take) pend_d = 1'b0;
    if (go_ok) begin
      pend_d = 1'b1;
      pwr_d  = reg_wdata[1];
    end
    if (done_scan) nvalid_d = 1'b0;
    if (cmd_wr && reg_wdata[2] && !scan_q) nvalid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q    <= '0;
      rga_q    <= '0;
      wval_q   <= '0;
      rval_q   <= '0;
      scan_q   <= 1'b0;
      nvalid_q <= 1'b0;
      pend_q   <= 1'b0;
      pwr_q    <= 1'b0;
    end else begin
      phy_q    <= phy_d;
      rga_q    <= rga_d;
      wval_q   <= wval_d;
      rval_q   <= rval_d;
      scan_q   <= scan_d;
      nvalid_q <= nvalid_d;
      pend_q   <= pend_d;
      pwr_q    <= pwr_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_ADDR:   reg_rdata = {19'd0, phy_q, 3'd0, rga_q};
      RA_WVAL:   reg_rdata = {16'd0, wval_q};
      RA_RVAL:   reg_rdata = {16'd0, rval_q};
      RA_STATUS: reg_rdata = {29'd0, nvalid_q, scan_q, busy};
      RA_CMD:    reg_rdata = {29'd0, scan_q, 2'b00};
      default:   reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        nvalid,
  input logic [15:0] rval
);
  a_r8_oe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r7_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc));

  a_r7_enable_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $fell(mdc));

  a_r11_pending_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    nvalid |-> busy);

  a_r6_result_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rval) |-> $past(busy));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .nvalid(nvalid_q), .rval(rval_q)
);

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  mdio_mgmt_master #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- per-clock model: MDC divider and output timing
  int edges = 0;
  int cyc = 0;
  logic pm, po, poe;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) edges <= edges + 1;
  end
  always @(negedge clk) begin
    if (rst_n) begin
      chk(mdc == ((edges / HALF) % 2), "R4 mdc waveform", 64'(mdc), 64'((edges / HALF) % 2));
      if (mdio_o !== po || mdio_oe !== poe)
        chk(pm == 1'b1 && mdc == 1'b0, "R7 output change off mdc fall", 64'(mdc), 64'(0));
    end
    pm = mdc; po = mdio_o; poe = mdio_oe;
  end

  // ---------------- PHY responder and frame recorder
  function automatic logic [15:0] resp_for(input int k);
    return 16'h3C5A ^ 16'(k * 16'h0111);
  endfunction

  logic [63:0] fb, fo;
  int  n = 0;
  bit  in_frame = 0;
  int  first_rise, last_rise;
  logic [63:0] q_bits[$];
  logic [63:0] q_oe[$];
  int  q_first[$];
  int  q_last[$];
  int  nframes = 0;

  always @(posedge mdc) begin
    if (!in_frame && mdio_oe) begin
      in_frame = 1; n = 0; fb = '0; fo = '0; first_rise = cyc;
    end
    if (in_frame) begin
      fb[63-n] = mdio_o;
      fo[63-n] = mdio_oe;
      n++;
      if (n == 64) begin
        last_rise = cyc;
        q_bits.push_back(fb); q_oe.push_back(fo);
        q_first.push_back(first_rise); q_last.push_back(last_rise);
        in_frame = 0;
        nframes++;
      end
    end
  end

  always @(negedge mdc) begin
    logic [15:0] v;
    v = resp_for(nframes);
    if (in_frame && n >= 48 && n < 64 && fb[29:28] == 2'b10) mdio_i = v[63-n];
    else mdio_i = 1'b1;
  end

  // ---------------- host tasks
  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd_reg(3'd3, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic wait_frames(input int k);
    for (int i = 0; i < 4000 && nframes < k; i++) @(negedge clk);
  endtask

  // ---------------- main sequence
  task automatic run_tests();
    logic [31:0] r;
    logic [63:0] expf;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), r);
      chk(r == 0, "R1 reset register", 64'(r), 64'd0);
    end
    chk(mdc == 0 && mdio_oe == 0, "R1 reset pins", 64'({mdc, mdio_oe}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    wr_reg(3'd0, 32'hFFFF_FFFF);
    rd_reg(3'd0, r);
    chk(r == 32'h0000_1F1F, "R2 address fields", 64'(r), 64'h1F1F);
    wr_reg(3'd0, 32'h0000_110A);
    wr_reg(3'd1, 32'hFFFF_A5C3);
    rd_reg(3'd1, r);
    chk(r == 32'h0000_A5C3, "R3 write value", 64'(r), 64'hA5C3);
    wr_reg(3'd2, 32'h0000_BEEF);
    rd_reg(3'd2, r);
    chk(r == 0, "R3 read result not writable", 64'(r), 64'd0);

    // single write frame, with a read go issued while busy
    wr_reg(3'd4, 32'h2);
    rd_reg(3'd3, r);
    chk(r == 32'h1, "R8 busy after accepted write", 64'(r), 64'h1);
    wr_reg(3'd4, 32'h1);
    wait_idle();
    repeat (DIV * 70) @(negedge clk);
    chk(nframes == 1, "R9 go ignored while busy", 64'(nframes), 64'd1);
    expf = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h0A, 2'b10, 16'hA5C3};
    chk(q_bits[0] == expf, "R5 write frame bits", q_bits[0], expf);
    chk(q_oe[0] == '1, "R5 write frame drive", q_oe[0], '1);

    // single read frame
    wr_reg(3'd0, 32'h0000_031F);
    wr_reg(3'd4, 32'h1);
    wait_idle();
    expf = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h03, 5'h1F, 18'd0};
    chk(q_bits[1][63:18] == expf[63:18], "R6 read header", 64'(q_bits[1][63:18]), 64'(expf[63:18]));
    chk(q_oe[1] == {46'h3FFF_FFFF_FFFF, 18'd0}, "R6 read release", q_oe[1], {46'h3FFF_FFFF_FFFF, 18'd0});
    rd_reg(3'd2, r);
    chk(r == 32'(resp_for(1)), "R6 read result", 64'(r), 64'(resp_for(1)));
    rd_reg(3'd3, r);
    chk(r == 0, "R8 idle after read", 64'(r), 64'd0);

    // scan
    wr_reg(3'd0, 32'h0000_0705);
    wr_reg(3'd4, 32'h4);
    rd_reg(3'd3, r);
    chk(r == 32'h7, "R11 R10 status after scan on", 64'(r), 64'h7);
    rd_reg(3'd4, r);
    chk(r == 32'h4, "R13 command readback", 64'(r), 64'h4);
    wait_frames(3);
    @(negedge clk);
    rd_reg(3'd3, r);
    chk(r[2] == 1'b1, "R11 pending until first scan end", 64'(r[2]), 64'd1);
    repeat (DIV + 2) @(negedge clk);
    rd_reg(3'd3, r);
    chk(r == 32'h3, "R11 pending cleared", 64'(r), 64'h3);
    rd_reg(3'd2, r);
    chk(r == 32'(resp_for(2)), "R10 first scan result", 64'(r), 64'(resp_for(2)));
    wr_reg(3'd4, 32'h6);
    wait_frames(4);
    rd_reg(3'd2, r);
    repeat (DIV + 2) @(negedge clk);
    rd_reg(3'd2, r);
    chk(r == 32'(resp_for(3)), "R10 second scan result", 64'(r), 64'(resp_for(3)));
    wr_reg(3'd4, 32'h0);
    rd_reg(3'd3, r);
    chk(r == 32'h1, "R12 frame continues after scan off", 64'(r), 64'h1);
    wait_idle();
    rd_reg(3'd2, r);
    chk(r == 32'(resp_for(4)), "R12 last scan result", 64'(r), 64'(resp_for(4)));
    repeat (DIV * 150) @(negedge clk);
    chk(nframes == 5, "R12 no frame after scan off", 64'(nframes), 64'd5);
    for (int k = 2; k < 5 && k < nframes; k++) begin
      expf = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h07, 5'h05, 18'd0};
      chk(q_bits[k][63:18] == expf[63:18], "R9 R10 scan frame is read", 64'(q_bits[k][63:18]), 64'(expf[63:18]));
      if (k > 2)
        chk(q_first[k] - q_last[k-1] == DIV, "R10 no gap between scan frames",
            64'(q_first[k] - q_last[k-1]), 64'(DIV));
    end
    rd_reg(3'd3, r);
    chk(r[31:3] == 0 && r[2:0] == 0, "R13 status upper zero", 64'(r), 64'd0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8 actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule